// File: doc/BRIEF.md
# Translation Table Update Engine

This block applies management commands to a small on-chip table of 64-bit translation entries. Each entry maps one page of an I/O window to a system address and carries two permission bits. There are four commands. One writes a single entry. One reads a single entry back. One fills a run of consecutive entries with the same value. One loads a run of entries from a list held in system memory, which the block fetches through a simple request/acknowledge read port.

Every command names an I/O bus address. The block first aligns that address down to the page size. It then subtracts the configured window base and shifts the result by the page shift to get the table index. Each command ends with a one-cycle completion pulse and a status: success or parameter error.

Every entry that is written successfully raises a one-cycle update notice, so that a translation cache can drop its stale copy. Software supplies the window base, the page shift and the active entry count on configuration inputs, and holds them stable while a command runs.

Top module: `tce_update_engine`

## Requirements
- R1: After reset every table entry reads back as zero, which is a fault entry with permission bits 00.
- R2: The command address is ANDed with the page mask ~(2^shift − 1). The index is (masked address − window base) >> shift, computed as unsigned 64-bit arithmetic, so an address below the base gives a huge index. An index at or above the active entry count ends the command with status 1 and writes nothing.
- R3: Opcode 0 writes the command value into the indexed entry. Opcode 1 returns the indexed entry on `rd_entry`. Both report status 0 when the index is in range.
- R4: Each successful entry write pulses `upd_valid` for one cycle, with these fields:
  - `upd_iova` = (masked address − base) & page mask
  - `upd_target` = entry & page mask
  - `upd_perm` = entry bits [1:0]

  A failed or skipped write produces no pulse.
- R5: Opcode 2 writes the command value into `count` consecutive entries. The address advances by 2^shift for each entry. A count of zero, or a count above the active entry count, gives status 1 with no write.
- R6: Opcode 3 rejects, with status 1 and no fetch and no write, any of these cases:
  - a count of zero
  - a count above 512
  - a list address whose low 12 bits are not all zero
- R7: Opcode 3 fetches list element i from list address + 8·i by holding `mem_req` with a stable `mem_addr` until `mem_ack`. The element is taken as big-endian: data lane k (bits 8k+7:8k) carries the byte at address + k, and lane 0 becomes the most significant byte of the entry. Each element is fetched before its index is checked.
- R8: A multi-entry command stops at the first out-of-range index and returns status 1. The entries written before that point keep their new values.
- R9: `busy` rises on the edge that accepts a command and falls on the edge that raises the one-cycle `done` pulse. A command rejected at acceptance pulses `done` without raising `busy`. `cmd_valid` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the table |
| cfg_bus_offset | input | 64 | Base I/O address of the window |
| cfg_page_shift | input | 6 | log2 of the page size |
| cfg_num_entries | input | $clog2(DEPTH+1) | Active entry count (at most DEPTH) |
| cmd_valid | input | 1 | Command presented (taken only when idle) |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list load |
| cmd_ioba | input | 64 | I/O bus address of the first page |
| cmd_value | input | 64 | Entry value (write, fill) or list address (load) |
| cmd_count | input | CNT_W | Page count for fill and load |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 1 | 0 success, 1 parameter error; valid with done |
| rd_entry | output | 64 | Entry returned by the last successful read |
| upd_valid | output | 1 | Entry-changed notice |
| upd_iova | output | 64 | Page-aligned window address of the changed entry |
| upd_target | output | 64 | Page-aligned target address of the new entry |
| upd_perm | output | 2 | Permission bits of the new entry |
| mem_req | output | 1 | List read request |
| mem_addr | output | 64 | List element address |
| mem_ack | input | 1 | List read data valid |
| mem_data | input | 64 | List read data, lane k = byte at address + k |

## Verification
The embedded assertions watch, on every cycle:
- the busy/done relationship and the ban on completion while busy;
- that notices only follow a write cycle of a write-type command;
- that every write lands below the active entry count;
- that list requests come only from a load, are 8-byte aligned, and hold their address until acknowledged.

The scenarios alone show the things that depend on values and sequences:
- the index arithmetic under two page sizes and window bases;
- each command's own rejection rule, and where a run stops part-way with its earlier writes kept;
- big-endian assembly of fetched elements;
- that a command offered while busy leaves the table untouched.

// File: rtl/tce_eng_pkg.sv
// Package: shared opcodes, state encoding, status values and helpers
// for the translation table update engine.
// Assumes 64-bit addresses and 64-bit entries throughout.
package tce_eng_pkg;

    localparam int unsigned W = 64;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LOAD = 2'd3
    } tce_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_EXEC  = 2'd2
    } eng_state_e;

    localparam logic ST_OK    = 1'b0;
    localparam logic ST_PARAM = 1'b1;

    // Page mask for a given shift: clears the in-page offset bits.
    function automatic logic [W-1:0] page_mask(input logic [5:0] shift);
        page_mask = ~((64'd1 << shift) - 64'd1);
    endfunction

    // Reorders bytes so that lane 0 (lowest address) becomes the MSB.
    function automatic logic [W-1:0] swap_bytes(input logic [W-1:0] d);
        for (int k = 0; k < 8; k++) begin
            swap_bytes[8*(7-k) +: 8] = d[8*k +: 8];
        end
    endfunction

endpackage

// File: rtl/tce_index_calc.sv
// Module: tce_index_calc
// Turns a page-aligned I/O address into a table index and a window
// address, and flags whether the index lies below the active count.
// Assumes the address is already masked and num_entries <= DEPTH.
module tce_index_calc
    import tce_eng_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned NE_W  = $clog2(DEPTH + 1)
) (
    input  logic [W-1:0]     ioba,
    input  logic [W-1:0]     bus_offset,
    input  logic [5:0]       shift,
    input  logic [NE_W-1:0]  num_entries,
    output logic [IDX_W-1:0] idx,
    output logic             in_range,
    output logic [W-1:0]     win_addr
);
    logic [W-1:0] rel;
    logic [W-1:0] full_idx;

    // Unsigned offset from the window base and the page number it names.
    always_comb begin
        rel      = ioba - bus_offset;
        full_idx = rel >> shift;
        in_range = full_idx < W'(num_entries);
        idx      = full_idx[IDX_W-1:0];
        win_addr = rel & page_mask(shift);
    end

endmodule

// File: rtl/tce_entry_store.sv
// Module: tce_entry_store
// Register array of DEPTH 64-bit entries, one write port and one
// combinational read port. Synchronous reset zeroes every entry.
// Assumes indices presented are below DEPTH.
module tce_entry_store
    import tce_eng_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // One entry: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent[g] <= wr_data;
            end
        end
    end

    // Read mux; an index past DEPTH reads as zero.
    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < DEPTH) rd_data = ent[rd_idx];
    end

endmodule

// File: rtl/tce_list_fetch.sv
// Module: tce_list_fetch
// Request side of the list read port. While active it presents the
// address of list slot i and converts returned big-endian data.
// Assumes the list base is 8-byte aligned and the FSM stays active
// until mem_ack.
module tce_list_fetch
    import tce_eng_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [W-1:0]     list_base,
    input  logic [CNT_W-1:0] slot,
    output logic             mem_req,
    output logic [W-1:0]     mem_addr,
    input  logic             mem_ack,
    input  logic [W-1:0]     mem_data,
    output logic             take,
    output logic [W-1:0]     entry
);
    // Address of element slot, request strobe and byte reordering.
    always_comb begin
        mem_req  = active;
        mem_addr = list_base + W'({slot, 3'b000});
        take     = active && mem_ack;
        entry    = swap_bytes(mem_data);
    end

    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

endmodule

// File: rtl/tce_update_engine.sv
// Module: tce_update_engine (top)
// Command sequencer for the translation table: single write, single
// read, fill run and list load, with per-command bounds rules, update
// notices and a busy/done handshake.
// Assumes configuration inputs are stable while busy and
// cfg_num_entries <= DEPTH.
module tce_update_engine
    import tce_eng_pkg::*;
#(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned LIST_MAX   = 512,
    parameter int unsigned LIST_ALIGN = 12,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned NE_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      cfg_bus_offset,
    input  logic [5:0]       cfg_page_shift,
    input  logic [NE_W-1:0]  cfg_num_entries,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [63:0]      cmd_ioba,
    input  logic [63:0]      cmd_value,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             busy,
    output logic             done,
    output logic             status,
    output logic [63:0]      rd_entry,
    output logic             upd_valid,
    output logic [63:0]      upd_iova,
    output logic [63:0]      upd_target,
    output logic [1:0]       upd_perm,
    output logic             mem_req,
    output logic [63:0]      mem_addr,
    input  logic             mem_ack,
    input  logic [63:0]      mem_data
);
    eng_state_e       state;
    tce_op_e          op_q;
    tce_op_e          op_in;
    logic [W-1:0]     cur_ioba;
    logic [W-1:0]     list_base;
    logic [W-1:0]     tce_cur;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] slot;
    logic [W-1:0]     mask;
    logic [W-1:0]     page_size;
    logic             pre_err;

    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic [W-1:0]     win_addr;
    logic             wr_en;
    logic [W-1:0]     rd_data;
    logic             fetch_take;
    logic [W-1:0]     fetch_entry;

    // Decode the incoming opcode and apply the acceptance-time rules.
    always_comb begin
        op_in     = tce_op_e'(cmd_op);
        mask      = page_mask(cfg_page_shift);
        page_size = 64'd1 << cfg_page_shift;
        pre_err   = 1'b0;
        case (op_in)
            OP_FILL: pre_err = (cmd_count == '0) ||
                               (32'(cmd_count) > 32'(cfg_num_entries));
            OP_LOAD: pre_err = (cmd_count == '0) ||
                               (32'(cmd_count) > LIST_MAX) ||
                               (cmd_value[LIST_ALIGN-1:0] != '0);
            default: pre_err = 1'b0;
        endcase
    end

    assign busy  = (state != S_IDLE);
    assign wr_en = (state == S_EXEC) && in_range && (op_q != OP_GET);

    tce_index_calc #(.DEPTH(DEPTH)) u_idx (
        .ioba        (cur_ioba),
        .bus_offset  (cfg_bus_offset),
        .shift       (cfg_page_shift),
        .num_entries (cfg_num_entries),
        .idx         (idx),
        .in_range    (in_range),
        .win_addr    (win_addr)
    );

    tce_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (tce_cur),
        .rd_idx  (idx),
        .rd_data (rd_data)
    );

    tce_list_fetch #(.CNT_W(CNT_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state == S_FETCH),
        .list_base (list_base),
        .slot      (slot),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_data  (mem_data),
        .take      (fetch_take),
        .entry     (fetch_entry)
    );

    // Command sequencer: accept, fetch, per-entry execute, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            op_q       <= OP_PUT;
            cur_ioba   <= '0;
            list_base  <= '0;
            tce_cur    <= '0;
            remain     <= '0;
            slot       <= '0;
            done       <= 1'b0;
            status     <= ST_OK;
            rd_entry   <= '0;
            upd_valid  <= 1'b0;
            upd_iova   <= '0;
            upd_target <= '0;
            upd_perm   <= '0;
        end else begin
            done      <= 1'b0;
            upd_valid <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q      <= op_in;
                        cur_ioba  <= cmd_ioba & mask;
                        tce_cur   <= cmd_value;
                        list_base <= cmd_value;
                        slot      <= '0;
                        remain    <= (op_in == OP_PUT || op_in == OP_GET)
                                     ? CNT_W'(1) : cmd_count;
                        if (pre_err) begin
                            done   <= 1'b1;
                            status <= ST_PARAM;
                        end else begin
                            state <= (op_in == OP_LOAD) ? S_FETCH : S_EXEC;
                        end
                    end
                end
                S_FETCH: begin
                    if (fetch_take) begin
                        tce_cur <= fetch_entry;
                        state   <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    if (!in_range) begin
                        done   <= 1'b1;
                        status <= ST_PARAM;
                        state  <= S_IDLE;
                    end else if (op_q == OP_GET) begin
                        rd_entry <= rd_data;
                        done     <= 1'b1;
                        status   <= ST_OK;
                        state    <= S_IDLE;
                    end else begin
                        upd_valid  <= 1'b1;
                        upd_iova   <= win_addr;
                        upd_target <= tce_cur & mask;
                        upd_perm   <= tce_cur[1:0];
                        cur_ioba   <= cur_ioba + page_size;
                        slot       <= slot + CNT_W'(1);
                        remain     <= remain - CNT_W'(1);
                        if (remain == CNT_W'(1)) begin
                            done   <= 1'b1;
                            status <= ST_OK;
                            state  <= S_IDLE;
                        end else begin
                            state <= (op_q == OP_LOAD) ? S_FETCH : S_EXEC;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    a_r9_done_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r9_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    a_r4_notice_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> ($past(busy) && ($past(op_q) != OP_GET)));

    a_r2_write_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(idx) < 32'(cfg_num_entries)));

    a_r6_fetch_only_load: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (op_q == OP_LOAD));

endmodule

// File: tb/tce_update_engine_tb_top.sv
module tce_update_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CNT_W      = 16;
    localparam int NE_W       = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic [63:0]      cfg_bus_offset;
    logic [5:0]       cfg_page_shift;
    logic [NE_W-1:0]  cfg_num_entries;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [63:0]      cmd_ioba;
    logic [63:0]      cmd_value;
    logic [CNT_W-1:0] cmd_count;
    logic             busy, done, status;
    logic [63:0]      rd_entry;
    logic             upd_valid;
    logic [63:0]      upd_iova, upd_target;
    logic [1:0]       upd_perm;
    logic             mem_req;
    logic [63:0]      mem_addr;
    logic             mem_ack;
    logic [63:0]      mem_data;

    int checks = 0;
    int errors = 0;
    int n_upd = 0;
    int n_fetch = 0;
    logic [63:0] last_iova, last_tgt;
    logic [1:0]  last_perm;

    logic [63:0] exp_tbl [DEPTH];
    int          exp_wr_total = 0;
    int          exp_fetch_total = 0;
    logic [63:0] exp_iova, exp_tgt, exp_rd;
    logic [1:0]  exp_perm;

    always #(CLK_PERIOD/2) clk = ~clk;

    tce_update_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_bus_offset(cfg_bus_offset), .cfg_page_shift(cfg_page_shift),
        .cfg_num_entries(cfg_num_entries),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ioba(cmd_ioba),
        .cmd_value(cmd_value), .cmd_count(cmd_count),
        .busy(busy), .done(done), .status(status), .rd_entry(rd_entry),
        .upd_valid(upd_valid), .upd_iova(upd_iova), .upd_target(upd_target),
        .upd_perm(upd_perm),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_data(mem_data)
    );

    // List element value the bench associates with a memory address.
    function automatic logic [63:0] list_word(input logic [63:0] a);
        list_word = {32'hA5000000 ^ a[31:0], a[31:0] | 32'h3};
    endfunction

    function automatic logic [63:0] to_lanes(input logic [63:0] v);
        for (int k = 0; k < 8; k++) to_lanes[8*k +: 8] = v[8*(7-k) +: 8];
    endfunction

    // Memory responder and notice monitor, sampled on the falling edge.
    always @(negedge clk) begin
        mem_ack  <= mem_req;
        mem_data <= to_lanes(list_word(mem_addr));
        if (rst_n && mem_req) n_fetch++;
        if (rst_n && upd_valid) begin
            n_upd++;
            last_iova = upd_iova;
            last_tgt  = upd_target;
            last_perm = upd_perm;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
        end
    endtask

    // Bench model of one command; returns the expected status.
    function automatic logic model(input int op, input logic [63:0] ioba,
                                   input logic [63:0] val, input int cnt);
        logic [63:0] msk, a, rel, idx, v;
        int n;
        logic st;
        msk = ~((64'd1 << cfg_page_shift) - 1);
        a = ioba & msk;
        st = 1'b1;
        n = (op < 2) ? 1 : cnt;
        if (op == 2 && (cnt == 0 || cnt > int'(cfg_num_entries))) return 1'b1;
        if (op == 3 && (cnt == 0 || cnt > 512 || val[11:0] != 0)) return 1'b1;
        for (int i = 0; i < n; i++) begin
            rel = a - cfg_bus_offset;
            idx = rel >> cfg_page_shift;
            if (op == 3) exp_fetch_total++;
            if (idx >= 64'(cfg_num_entries)) begin
                st = 1'b1;
                break;
            end
            if (op == 1) begin
                exp_rd = exp_tbl[idx];
                st = 1'b0;
            end else begin
                v = (op == 3) ? list_word(val + 64'(8*i)) : val;
                exp_tbl[idx] = v;
                exp_wr_total++;
                exp_iova = rel & msk;
                exp_tgt  = v & msk;
                exp_perm = v[1:0];
                st = 1'b0;
            end
            a = a + (64'd1 << cfg_page_shift);
        end
        return st;
    endfunction

    // Drive one command, wait for done, compare against the model.
    task automatic run(input int op, input logic [63:0] ioba,
                       input logic [63:0] val, input int cnt, input string tag);
        logic es;
        int wd;
        es = model(op, ioba, val, cnt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_ioba = ioba;
        cmd_value = val; cmd_count = CNT_W'(cnt);
        @(negedge clk);
        cmd_valid = 1'b0;
        wd = 0;
        while (!done && wd < 2000) begin
            @(negedge clk);
            wd++;
        end
        check(done, {tag, " done"}, 64'(done), 64'd1);
        check(status == es, {tag, " status"}, 64'(status), 64'(es));
        check(!busy, {tag, " R9 busy low at done"}, 64'(busy), 64'd0);
        if (op == 1 && es == 1'b0)
            check(rd_entry == exp_rd, {tag, " R3 read data"}, rd_entry, exp_rd);
        @(negedge clk);
        check(!done, {tag, " R9 done one cycle"}, 64'(done), 64'd0);
        check(n_upd == exp_wr_total, {tag, " R4 notice count"},
              64'(n_upd), 64'(exp_wr_total));
        check(n_fetch == exp_fetch_total, {tag, " R7 fetch count"},
              64'(n_fetch), 64'(exp_fetch_total));
        if (n_upd > 0 && op != 1) begin
            check(last_iova == exp_iova, {tag, " R4 iova"}, last_iova, exp_iova);
            check(last_tgt == exp_tgt, {tag, " R4 target"}, last_tgt, exp_tgt);
            check(last_perm == exp_perm, {tag, " R4 perm"},
                  64'(last_perm), 64'(exp_perm));
        end
    endtask

    // Read back every active entry plus the first out-of-range one.
    task automatic sweep(input string tag);
        for (int i = 0; i <= int'(cfg_num_entries); i++)
            run(1, cfg_bus_offset + (64'(i) << cfg_page_shift), 64'd0, 1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_tbl[i] = 64'd0;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_ioba = '0;
        cmd_value = '0; cmd_count = '0; mem_ack = 1'b0; mem_data = '0;
        cfg_bus_offset = 64'h10000; cfg_page_shift = 6'd12;
        cfg_num_entries = NE_W'(12);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(!busy && !done && !upd_valid && !mem_req, "R9 idle after reset",
              {60'd0, busy, done, upd_valid, mem_req}, 64'd0);

        // R1: every entry reads zero after reset.
        sweep("R1 reset sweep");

        // R2 R3 R4: single writes with in-page garbage in the address.
        for (int i = 0; i < 12; i++)
            run(0, 64'h10000 + (64'(i) << 12) + 64'(i * 37),
                64'h0000_00AB_0000_0000 + (64'(i) << 12) + 64'(i % 4), 1,
                "R2 R3 put");
        sweep("R3 put sweep");
        run(0, 64'h10000 + (64'd12 << 12), 64'hDEAD_0003, 1, "R2 index at count");
        run(0, 64'h0F000, 64'hDEAD_0003, 1, "R2 below base");
        run(1, 64'h0F000, 64'd0, 1, "R2 read below base");

        // R5 R8: fill runs.
        run(2, 64'h10000 + (64'd3 << 12), 64'h0000_5555_0000_1002, 5, "R5 fill");
        run(2, 64'h10000, 64'h1111_0001, 13, "R5 fill over count");
        run(2, 64'h10000, 64'h1111_0001, 0, "R5 fill zero");
        run(2, 64'h10000 + (64'd9 << 12), 64'h7777_0001, 6, "R8 fill past end");
        sweep("R5 R8 fill sweep");

        // R6 R7 R8: list loads.
        run(3, 64'h10000, 64'h2000, 4, "R7 load");
        run(3, 64'h10000, 64'h2008, 2, "R6 load misaligned");
        run(3, 64'h10000, 64'h3000, 513, "R6 load over 512");
        run(3, 64'h10000, 64'h3000, 0, "R6 load zero");
        run(3, 64'h10000 + (64'd8 << 12), 64'h5000, 512, "R8 load past end");
        sweep("R7 R8 load sweep");

        // Second configuration: small pages, high base, full depth.
        cfg_bus_offset = 64'h4000_0000; cfg_page_shift = 6'd6;
        cfg_num_entries = NE_W'(16);
        run(2, 64'h4000_0000, 64'h0, 16, "R5 clear full table");
        for (int i = 0; i < 16; i++)
            run(0, 64'h4000_0000 + (64'(i) << 6) + 64'd63,
                64'hCAFE_0000_0000_0000 + (64'(i) << 6) + 64'(3 - i % 4), 1,
                "R2 R4 put small pages");
        sweep("R3 small page sweep");
        run(3, 64'h4000_0000 + (64'd10 << 6), 64'h8000, 6, "R7 load small pages");
        sweep("R7 small page load sweep");

        // R9: a command offered while busy is ignored.
        begin
            logic es;
            int wd;
            es = model(2, 64'h4000_0000, 64'h9999_0002, 8);
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'd2; cmd_ioba = 64'h4000_0000;
            cmd_value = 64'h9999_0002; cmd_count = CNT_W'(8);
            @(negedge clk);
            check(busy, "R9 busy after accept", 64'(busy), 64'd1);
            cmd_op = 2'd0; cmd_ioba = 64'h4000_0000 + (64'd14 << 6);
            cmd_value = 64'hBAD0_0003; cmd_count = CNT_W'(1);
            @(negedge clk);
            cmd_valid = 1'b0;
            check(busy, "R9 busy mid run", 64'(busy), 64'd1);
            wd = 0;
            while (!done && wd < 2000) begin
                @(negedge clk);
                wd++;
            end
            check(done && status == es, "R9 fill status", 64'(status), 64'(es));
            @(negedge clk);
            check(n_upd == exp_wr_total, "R9 notice count", 64'(n_upd),
                  64'(exp_wr_total));
        end
        sweep("R9 ignored command sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule